// File: doc/BRIEF.md
# Split-Region Data Memory with Concurrent Operand Read

This block is the data store of a 16-bit signal-processing core. Every address is a 16-bit byte address, and storage is held as 16-bit words. The storage is split into a lower X region and an upper Y region. The boundary between them is a build-time parameter that software cannot move.

The block has three ports. An X read port and an X write port treat the whole implemented storage as one flat space. Ordinary loads and all stores, including stores from signal-processing instructions, use these two ports. A third port reads words from the Y region only. It runs in the same cycle as an X read, so a dual-operand multiply-accumulate can fetch both of its operands at once.

The X ports take either a byte or a word. Byte access uses the address LSb to pick the lane. A word access at an odd address is never carried out. Instead it raises an address-fault pulse that trap logic elsewhere can act on.

Top module: `xy_data_mem`

## Requirements
- R1: A word written to an even address reads back unchanged on the X read port. The read data appears one clock after the edge that samples `xr_en_i`.
- R2: A byte read (`xr_byte_i`=1) returns the low byte of the containing word when address bit 0 is 0 and the high byte when it is 1. The byte is placed in `xr_data_o[7:0]` and `xr_data_o[15:8]` is zero.
- R3: A byte write stores `xw_data_i[7:0]` in the lane picked by address bit 0 (0 = bits 7:0, 1 = bits 15:8). The other byte of the word keeps its old value.
- R4: A word access at an odd address on any port is not performed. A write of this kind changes no storage, and a read of this kind returns zero. `addr_fault_o` is high for the single cycle after such an access.
- R5: The Y port returns the addressed word one clock after `yr_en_i`, in the same cycle as an X read issued together with it. Its valid addresses are Y_BASE up to but not including Y_END.
- R6: A Y read outside [Y_BASE, Y_END) returns zero. `yr_range_err_o` is high for the single cycle after it.
- R7: Writes and X reads cover the full unified range [0, 2*MEM_WORDS), so a word written inside the Y region is visible on the Y port.
- R8: When a read and a write hit the same word in the same cycle, the read returns the word as it was before the write.
- R9: While a read port is not enabled, its data output holds its last value. The fault and range flags drop back to zero.
- R10: During reset, both read data outputs and both flags are zero.
- R11: An X read at or above 2*MEM_WORDS returns zero, and an X write there changes nothing. Neither raises a flag unless the address is misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xr_en_i | input | 1 | X read request |
| xr_addr_i | input | 16 | X read byte address |
| xr_byte_i | input | 1 | X read is a byte access |
| xr_data_o | output | 16 | X read data, one cycle after request |
| xw_en_i | input | 1 | X write request |
| xw_addr_i | input | 16 | X write byte address |
| xw_byte_i | input | 1 | X write is a byte access |
| xw_data_i | input | 16 | X write data (byte writes use bits 7:0) |
| yr_en_i | input | 1 | Y word read request |
| yr_addr_i | input | 16 | Y read byte address |
| yr_data_o | output | 16 | Y read data, one cycle after request |
| yr_range_err_o | output | 1 | Y address was outside the Y region |
| addr_fault_o | output | 1 | A misaligned word access was rejected |

## Verification
Every result is due exactly one clock after the rising edge that samples the request. This holds for both read data outputs, the fault pulse and the range pulse. A write becomes visible to a read issued on the next cycle. The bench changes inputs on the falling edge, waits through one rising edge and compares all four outputs on the following falling edge. It checks against a model that held the memory contents from before that rising edge, which is how it checks same-cycle collisions. On idle cycles it expects the previous read data again and both flags low.

// File: rtl/xy_mem_pkg.sv
package xy_mem_pkg;
  localparam int unsigned EA_W   = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = BYTE_W * LANES;

  // zero-extended byte of a word, lane chosen by address lsb
  function automatic logic [WORD_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic lsb);
    logic [WORD_W-1:0] r;
    r = '0;
    r[BYTE_W-1:0] = lsb ? w[WORD_W-1 -: BYTE_W] : w[BYTE_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/xy_port_chk.sv
module xy_port_chk import xy_mem_pkg::*; #(
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 1024
) (
  input  logic            en_i,
  input  logic [EA_W-1:0] addr_i,
  input  logic            byte_i,
  output logic            misalign_o,
  output logic            outside_o,
  output logic            go_o
);
  logic below, above;

  generate
    if (LO == 0) begin : g_no_lo
      assign below = 1'b0;
    end else begin : g_lo
      assign below = 32'(addr_i) < LO;
    end
  endgenerate

  assign above      = 32'(addr_i) >= HI;
  assign misalign_o = en_i & ~byte_i & addr_i[0];
  assign outside_o  = en_i & (below | above);
  assign go_o       = en_i & ~misalign_o & ~outside_o;
endmodule

// File: rtl/xy_wr_lanes.sv
module xy_wr_lanes import xy_mem_pkg::*; (
  input  logic              go_i,
  input  logic              lsb_i,
  input  logic              byte_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // byte writes replicate the low byte so any lane can take it
    assign wdata_o[l*BYTE_W +: BYTE_W] = byte_i ? data_i[BYTE_W-1:0]
                                                : data_i[l*BYTE_W +: BYTE_W];
    assign be_o[l] = go_i & (~byte_i | (lsb_i == l[0]));
  end
endmodule

// File: rtl/xy_mem_array.sv
module xy_mem_array import xy_mem_pkg::*; #(
  parameter int unsigned WORDS = 512,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  be_i,
  input  logic [IDX_W-1:0]  wa_i,
  input  logic [WORD_W-1:0] wd_i,
  input  logic              ra_en_i,
  input  logic [IDX_W-1:0]  ra_i,
  output logic [WORD_W-1:0] ra_o,
  input  logic              rb_en_i,
  input  logic [IDX_W-1:0]  rb_i,
  output logic [WORD_W-1:0] rb_o
);
  logic [WORD_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < int'(LANES); l++) begin
      if (be_i[l]) mem_q[wa_i][l*BYTE_W +: BYTE_W] <= wd_i[l*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_o <= '0;
      rb_o <= '0;
    end else begin
      if (ra_en_i) ra_o <= mem_q[ra_i];
      if (rb_en_i) rb_o <= mem_q[rb_i];
    end
  end

  assert_old_data_on_collision_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_en_i && (be_i != '0) && ra_i == wa_i) |=> ra_o == $past(mem_q[ra_i]));
endmodule

// File: rtl/xy_data_mem.sv
module xy_data_mem import xy_mem_pkg::*; #(
  parameter int unsigned MEM_WORDS = 512,
  parameter int unsigned Y_BASE    = 32'h0200,
  parameter int unsigned Y_END     = 32'h0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xr_en_i,
  input  logic [EA_W-1:0]   xr_addr_i,
  input  logic              xr_byte_i,
  output logic [WORD_W-1:0] xr_data_o,
  input  logic              xw_en_i,
  input  logic [EA_W-1:0]   xw_addr_i,
  input  logic              xw_byte_i,
  input  logic [WORD_W-1:0] xw_data_i,
  input  logic              yr_en_i,
  input  logic [EA_W-1:0]   yr_addr_i,
  output logic [WORD_W-1:0] yr_data_o,
  output logic              yr_range_err_o,
  output logic              addr_fault_o
);
  localparam int unsigned IDX_W     = $clog2(MEM_WORDS);
  localparam int unsigned SPACE_END = 2 * MEM_WORDS;

  logic xr_mis, xr_out, xr_go;
  logic xw_mis, xw_out, xw_go;
  logic yr_mis, yr_out, yr_go;

  xy_port_chk #(.LO(0), .HI(SPACE_END)) i_xr_chk (
    .en_i(xr_en_i), .addr_i(xr_addr_i), .byte_i(xr_byte_i),
    .misalign_o(xr_mis), .outside_o(xr_out), .go_o(xr_go));

  xy_port_chk #(.LO(0), .HI(SPACE_END)) i_xw_chk (
    .en_i(xw_en_i), .addr_i(xw_addr_i), .byte_i(xw_byte_i),
    .misalign_o(xw_mis), .outside_o(xw_out), .go_o(xw_go));

  // Y port is word-only
  xy_port_chk #(.LO(Y_BASE), .HI(Y_END)) i_yr_chk (
    .en_i(yr_en_i), .addr_i(yr_addr_i), .byte_i(1'b0),
    .misalign_o(yr_mis), .outside_o(yr_out), .go_o(yr_go));

  logic [LANES-1:0]  wr_be;
  logic [WORD_W-1:0] wr_data;

  xy_wr_lanes i_wr_lanes (
    .go_i(xw_go), .lsb_i(xw_addr_i[0]), .byte_i(xw_byte_i),
    .data_i(xw_data_i), .be_o(wr_be), .wdata_o(wr_data));

  logic [WORD_W-1:0] x_word, y_word;

  xy_mem_array #(.WORDS(MEM_WORDS)) i_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .be_i(wr_be), .wa_i(xw_addr_i[IDX_W:1]), .wd_i(wr_data),
    .ra_en_i(xr_en_i), .ra_i(xr_addr_i[IDX_W:1]), .ra_o(x_word),
    .rb_en_i(yr_en_i), .rb_i(yr_addr_i[IDX_W:1]), .rb_o(y_word));

  logic xr_kill_q, xr_byte_q, xr_lsb_q, yr_kill_q, fault_q, range_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xr_kill_q <= 1'b1;
      xr_byte_q <= 1'b0;
      xr_lsb_q  <= 1'b0;
      yr_kill_q <= 1'b1;
      fault_q   <= 1'b0;
      range_q   <= 1'b0;
    end else begin
      if (xr_en_i) begin
        xr_kill_q <= ~xr_go;
        xr_byte_q <= xr_byte_i;
        xr_lsb_q  <= xr_addr_i[0];
      end
      if (yr_en_i) yr_kill_q <= ~yr_go;
      fault_q <= xr_mis | xw_mis | yr_mis;
      range_q <= yr_out;
    end
  end

  // lane selection after the read register keeps the array path short
  assign xr_data_o = xr_kill_q ? '0 :
                     xr_byte_q ? pick_byte(x_word, xr_lsb_q) : x_word;
  assign yr_data_o      = yr_kill_q ? '0 : y_word;
  assign addr_fault_o   = fault_q;
  assign yr_range_err_o = range_q;

  assert_byte_read_zero_ext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xr_en_i && xr_byte_i) |=> xr_data_o[WORD_W-1:BYTE_W] == '0);

  assert_misaligned_read_faults_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xr_en_i && !xr_byte_i && xr_addr_i[0]) |=> (addr_fault_o && xr_data_o == '0));

  assert_misaligned_write_faults_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xw_en_i && !xw_byte_i && xw_addr_i[0]) |=> addr_fault_o);

  assert_y_outside_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (yr_en_i && (32'(yr_addr_i) < Y_BASE || 32'(yr_addr_i) >= Y_END))
      |=> (yr_range_err_o && yr_data_o == '0));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xr_en_i && !yr_en_i) |=> ($stable(xr_data_o) && $stable(yr_data_o)));

  assert_no_unrequested_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xr_en_i && !xw_en_i && !yr_en_i) |=> (!addr_fault_o && !yr_range_err_o));
endmodule

// File: tb/test_xy_data_mem.sv
`timescale 1ns/1ps
module test_xy_data_mem;
  localparam int MW = 512;
  localparam logic [15:0] YB  = 16'h0200;
  localparam logic [15:0] YE  = 16'h0400;
  localparam logic [15:0] TOP = 16'h0400;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        xr_en, xr_byte, xw_en, xw_byte, yr_en;
  logic [15:0] xr_addr, xw_addr, xw_data, yr_addr;
  logic [15:0] xr_data, yr_data;
  logic        yr_rerr, fault;

  xy_data_mem i_xy_data_mem (
    .clk_i(clk), .rst_ni(rst_ni),
    .xr_en_i(xr_en), .xr_addr_i(xr_addr), .xr_byte_i(xr_byte), .xr_data_o(xr_data),
    .xw_en_i(xw_en), .xw_addr_i(xw_addr), .xw_byte_i(xw_byte), .xw_data_i(xw_data),
    .yr_en_i(yr_en), .yr_addr_i(yr_addr), .yr_data_o(yr_data),
    .yr_range_err_o(yr_rerr), .addr_fault_o(fault));

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] ref_mem [MW];
  logic [15:0] e_xr = '0, e_yr = '0;
  logic        e_flt = 1'b0, e_rng = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] x_expect(input logic [15:0] a, input logic b);
    logic [15:0] w;
    if ((!b && a[0]) || a >= TOP) return 16'h0;
    w = ref_mem[a[9:1]];
    if (!b) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic op(input logic re, input logic [15:0] ra, input logic rb,
                    input logic we, input logic [15:0] wa, input logic wb,
                    input logic [15:0] wd,
                    input logic ye, input logic [15:0] ya, input string tag);
    logic yout;
    xr_en = re; xr_addr = ra; xr_byte = rb;
    xw_en = we; xw_addr = wa; xw_byte = wb; xw_data = wd;
    yr_en = ye; yr_addr = ya;
    // expectations from memory state before this edge
    if (re) e_xr = x_expect(ra, rb);
    yout = (ya < YB) || (ya >= YE);
    e_rng = ye && yout;
    if (ye) e_yr = (yout || ya[0]) ? 16'h0 : ref_mem[ya[9:1]];
    e_flt = (re && !rb && ra[0]) || (we && !wb && wa[0]) || (ye && ya[0]);
    if (we && !(!wb && wa[0]) && wa < TOP) begin
      if (!wb) ref_mem[wa[9:1]] = wd;
      else if (wa[0]) ref_mem[wa[9:1]][15:8] = wd[7:0];
      else ref_mem[wa[9:1]][7:0] = wd[7:0];
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "xr_data", xr_data, e_xr);
    chk(tag, "yr_data", yr_data, e_yr);
    chk(tag, "addr_fault", {15'h0, fault}, {15'h0, e_flt});
    chk(tag, "yr_range_err", {15'h0, yr_rerr}, {15'h0, e_rng});
  endtask

  task automatic idle(input string tag);
    op(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    xr_en = 0; xr_addr = 0; xr_byte = 0;
    xw_en = 0; xw_addr = 0; xw_byte = 0; xw_data = 0;
    yr_en = 0; yr_addr = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "xr_data", xr_data, 16'h0);
    chk("R10", "yr_data", yr_data, 16'h0);
    chk("R10", "flags", {14'h0, fault, yr_rerr}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7 fill the whole unified space with word writes
    for (int i = 0; i < MW; i++)
      op(1'b0, 16'h0, 1'b0, 1'b1, 16'(2 * i), 1'b0, 16'(i * 37) ^ 16'hA5C3,
         1'b0, 16'h0, "R7");

    // R1 word write then read
    op(0, 0, 0, 1, 16'h0010, 0, 16'hBEEF, 0, 0, "R1");
    op(1, 16'h0010, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2 byte reads of both lanes
    op(1, 16'h0010, 1, 0, 0, 0, 0, 0, 0, "R2");
    op(1, 16'h0011, 1, 0, 0, 0, 0, 0, 0, "R2");
    // R3 byte writes to each lane, then whole word
    op(0, 0, 0, 1, 16'h0011, 1, 16'h3C12, 0, 0, "R3");
    op(1, 16'h0010, 0, 1, 16'h0020, 1, 16'hFF77, 0, 0, "R3");
    op(1, 16'h0020, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R4 misaligned word write is dropped, misaligned read returns zero
    op(0, 0, 0, 1, 16'h0031, 0, 16'h1234, 0, 0, "R4");
    op(1, 16'h0030, 0, 0, 0, 0, 0, 0, 0, "R4");
    op(1, 16'h0031, 0, 0, 0, 0, 0, 0, 0, "R4");
    op(0, 0, 0, 0, 0, 0, 0, 1, 16'h0203, "R4");
    // R7 write inside Y region, R5 concurrent X and Y reads
    op(0, 0, 0, 1, 16'h0300, 0, 16'hC0DE, 0, 0, "R7");
    op(1, 16'h0010, 0, 0, 0, 0, 0, 1, 16'h0300, "R5");
    op(1, 16'h0300, 0, 0, 0, 0, 0, 1, YB, "R5");
    op(0, 0, 0, 0, 0, 0, 0, 1, 16'h03FE, "R5");
    // R6 Y boundaries
    op(0, 0, 0, 0, 0, 0, 0, 1, 16'h01FE, "R6");
    op(0, 0, 0, 0, 0, 0, 0, 1, YE, "R6");
    op(0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFE, "R6");
    // R8 same-cycle read and write of one word
    op(1, 16'h0040, 0, 1, 16'h0040, 0, 16'h5A5A, 0, 0, "R8");
    op(1, 16'h0040, 0, 0, 0, 0, 0, 0, 0, "R8");
    op(1, 16'h0040, 1, 1, 16'h0041, 1, 16'h0099, 1, 16'h0240, "R8");
    op(0, 0, 0, 1, 16'h0240, 0, 16'h7E7E, 1, 16'h0240, "R8");
    // R9 idle hold and flag drop
    op(1, 16'h0040, 0, 0, 0, 0, 0, 1, 16'h0302, "R9");
    idle("R9");
    idle("R9");
    // R11 beyond implemented range
    op(0, 0, 0, 1, 16'h0410, 0, 16'hDEAD, 0, 0, "R11");
    op(1, 16'h0010, 0, 0, 0, 0, 0, 0, 0, "R11");
    op(1, 16'h8000, 0, 0, 0, 0, 0, 0, 0, "R11");
    op(1, 16'h0401, 1, 0, 0, 0, 0, 0, 0, "R11");

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ra, wa, ya;
      ra = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom) & 16'h03FF;
      wa = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom) & 16'h03FF;
      ya = ($urandom % 6 == 0) ? 16'($urandom) : 16'($urandom % 16'h0500);
      if ($urandom % 4 != 0) ra[0] = 1'b0;
      if ($urandom % 4 != 0) wa[0] = 1'b0;
      if ($urandom % 5 != 0) ya[0] = 1'b0;
      op(1'($urandom), ra, 1'($urandom), 1'($urandom), wa, 1'($urandom),
         16'($urandom), 1'($urandom), ya, "random R1 R2 R3 R4 R5 R6 R8 R9 R11");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule